// File: doc/BRIEF.md
# Serial Management Slave with Register File

This block is a slave for a two-wire management bus of the SMBus/I2C kind. A fast system clock samples the clock line and the data line. The block finds start, repeated-start and stop conditions and matches its 7-bit device address. It then lets a host write and read sixteen 8-bit internal registers. The block has one register pointer. The host loads the pointer with the second byte of a write, and the pointer steps by one after each data byte, so a host can move a run of bytes in one transaction.

A device address is made of a fixed upper part and a lower part that comes from four strap inputs. Up to sixteen of these slaves can therefore share one bus. The block never drives the data line high. It only pulls the line low, through an output-enable signal, to acknowledge a byte or to send a zero bit. A timer watches both lines and raises a bus-idle flag when they stay high long enough. The same flag aborts a transaction whose clock line has been held high for too long. An enable input switches the whole interface on and off.

Top module: `smb_regslave`

## Requirements
- R1: The slave answers the 7-bit address made of binary 101 in bits 6..4 and the strap inputs in bits 3..0, with bit 0 of the address byte giving the direction (0 write, 1 read). Bytes travel MSB first. The slave acknowledges by holding SDA low during the ninth clock.
- R2: When the address differs, the slave does not acknowledge. It does not pull SDA low at any point and ignores every byte until the next START or STOP.
- R3: In a write, the low four bits of the byte that follows the address set the register pointer. Each later byte is stored at the pointer. The slave acknowledges the pointer byte and every data byte.
- R4: The pointer advances by one after each byte written or read, and it wraps from 15 to 0.
- R5: After the pointer is set, a repeated START with the read address makes the slave send the register at the pointer, MSB first. Each ACK from the host makes it send the next register.
- R6: When the host answers a read byte with NACK, the slave releases SDA and sends nothing more until the next START.
- R7: While `en` is low, the slave never pulls SDA low, ignores all bus activity, and keeps its register contents.
- R8: A START at any point, including in the middle of a byte, begins a new address phase and drops any partly received byte. The slave asserts its SDA drive only right after a falling edge of SCL.
- R9: `bus_idle` goes high once both synchronised lines have been high for IDLE_CYCLES consecutive clocks, and it goes low when either line falls. When this timeout occurs in the middle of a transaction, the transaction is abandoned.
- R10: After reset, `sda_oe` and `bus_idle` are low, all registers hold 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Interface enable; low makes the slave deaf and silent |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| strap | input | 4 | Lower four address bits from strap pins |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| bus_idle | output | 1 | Both lines have been high for the idle timeout |

## Verification
The bench checks that the pointer wraps from 15 to 0 in both a write and a read. A design that saturated or overflowed the pointer would put data in the wrong register. The bench sends a foreign address and also runs a transaction with the enable low, watching SDA on every clock. A design that leaked an ACK or a stray zero bit would pull the line low or change a register. The bench gives a START in the middle of a byte and holds SCL high until the timeout fires. A slave that kept a half-received byte, or that failed to abort, would then store or acknowledge bytes it should drop. After a NACK the bench keeps clocking, so a slave that went on sending data would show zero bits.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int SMB_BYTE_W   = 8;
    localparam int SMB_ADDR_W   = 7;
    localparam int SMB_STRAP_W  = 4;
    localparam int SMB_DEF_REGS = 16;
    localparam logic [2:0] SMB_FIXED_HI = 3'b101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } smb_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } smb_bus_ev_t;

    function automatic logic smb_addr_hit(input logic [SMB_BYTE_W-1:0] addr_byte,
                                          input logic [SMB_STRAP_W-1:0] strap_bits);
        return addr_byte[SMB_BYTE_W-1:1] == {SMB_FIXED_HI, strap_bits};
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    output smb_bus_ev_t ev
);
    logic [1:0] scl_pipe, sda_pipe;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= 2'b11;
            sda_pipe <= 2'b11;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[0], scl_in};
            sda_pipe <= {sda_pipe[0], sda_in};
            scl_q    <= scl_pipe[1];
            sda_q    <= sda_pipe[1];
        end
    end

    always_comb begin
        ev.scl   = scl_pipe[1];
        ev.sda   = sda_pipe[1];
        ev.rise  = scl_pipe[1] & ~scl_q;
        ev.fall  = ~scl_pipe[1] & scl_q;
        ev.start = scl_pipe[1] & scl_q & sda_q & ~sda_pipe[1];
        ev.stop  = scl_pipe[1] & scl_q & ~sda_q & sda_pipe[1];
    end
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
    parameter int IDLE_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic bus_idle
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

    logic [CNT_W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (scl_s && sda_s) begin
            if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    assign bus_idle = (hi_cnt == CNT_MAX);

    AST_IDLE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_idle) |-> $past(scl_s && sda_s)); // R9
    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (!scl_s || !sda_s) |=> !bus_idle); // R9
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
    import smb_pkg::*;
#(
    parameter int NUM_REGS    = SMB_DEF_REGS,
    parameter int IDLE_CYCLES = 200
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   scl_in,
    input  logic                   sda_in,
    input  logic [SMB_STRAP_W-1:0] strap,
    output logic                   sda_oe,
    output logic                   bus_idle
);
    localparam int PTR_W = $clog2(NUM_REGS);
    localparam int BCNT_W = $clog2(SMB_BYTE_W + 1);
    localparam logic [BCNT_W-1:0] FULL = BCNT_W'(SMB_BYTE_W);
    localparam logic [PTR_W-1:0] LAST_REG = PTR_W'(NUM_REGS - 1);

    smb_bus_ev_t            ev;
    smb_state_t             state;
    logic [BCNT_W-1:0]      bitcnt;
    logic [SMB_BYTE_W-1:0]  shreg, txreg, rd_data;
    logic [PTR_W-1:0]       ptr, ptr_inc;
    logic                   is_read, host_ack, abort, wr_en;

    smb_line_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    smb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .scl_s    (ev.scl),
        .sda_s    (ev.sda),
        .bus_idle (bus_idle)
    );

    smb_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(SMB_BYTE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (ptr),
        .wr_data (shreg),
        .rd_idx  (ptr),
        .rd_data (rd_data)
    );

    assign abort   = bus_idle && (state != ST_IDLE);
    assign ptr_inc = (ptr == LAST_REG) ? '0 : ptr + 1'b1;
    assign wr_en   = en && !ev.stop && !ev.start && !abort &&
                     (state == ST_WDATA) && ev.fall && (bitcnt == FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
        end else if (!en || ev.stop || abort) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (ev.rise && bitcnt != FULL) begin
                        shreg  <= {shreg[SMB_BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.fall && bitcnt == FULL) begin
                        bitcnt <= '0;
                        case (state)
                            ST_ADDR: begin
                                if (smb_addr_hit(shreg, strap)) begin
                                    is_read <= shreg[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state   <= ST_IGNORE;
                                end
                            end
                            ST_PTR: begin
                                ptr    <= shreg[PTR_W-1:0];
                                sda_oe <= 1'b1;
                                state  <= ST_PTR_ACK;
                            end
                            default: begin
                                ptr    <= ptr_inc;
                                sda_oe <= 1'b1;
                                state  <= ST_WDATA_ACK;
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.fall) begin
                        bitcnt <= '0;
                        if (is_read) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[SMB_BYTE_W-1];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (ev.fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (ev.rise && bitcnt != FULL) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.fall && bitcnt == FULL) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr_inc;
                        state  <= ST_RACK;
                    end else if (ev.fall) begin
                        txreg  <= {txreg[SMB_BYTE_W-2:0], 1'b0};
                        sda_oe <= ~txreg[SMB_BYTE_W-2];
                    end
                end
                ST_RACK: begin
                    if (ev.rise) begin
                        host_ack <= ~ev.sda;
                    end else if (ev.fall) begin
                        bitcnt <= '0;
                        if (host_ack) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[SMB_BYTE_W-1];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_IGNORE;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    AST_EN_LOW_SILENT: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sda_oe); // R7
    AST_OE_RISE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(ev.fall)); // R8
    AST_IGNORE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe); // R2
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ptr == LAST_REG) |=> (ptr == '0)); // R4
    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RACK && ev.fall && !host_ack && en && !abort) |=> (state == ST_IGNORE && !sda_oe)); // R6
    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= FULL); // R1
endmodule

// File: tb/smb_regslave_bench.sv
module smb_regslave_bench;
    localparam int H    = 8;
    localparam int IDLE = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       scl = 1'b1;
    logic       sda_host = 1'b1;
    logic [3:0] strap = 4'h5;
    logic       sda_oe, bus_idle;
    logic       sda_line;

    assign sda_line = sda_host & ~sda_oe;

    smb_regslave #(.NUM_REGS(16), .IDLE_CYCLES(IDLE)) u_smb_regslave (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .scl_in   (scl),
        .sda_in   (sda_line),
        .strap    (strap),
        .sda_oe   (sda_oe),
        .bus_idle (bus_idle)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int drive_viol = 0;
    bit watch_silent = 1'b0;
    bit done = 1'b0;
    logic [7:0] ref_regs [16];

    always @(posedge clk) if (watch_silent && sda_oe) drive_viol++;

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
        end
    endtask

    function automatic bit exp_match(input logic [6:0] a, input logic [3:0] s, input logic e);
        return e && (a == {3'b101, s});
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_host = 1'b1; tick(H);
        scl = 1'b1;      tick(H);
        sda_host = 1'b0; tick(H);
        scl = 1'b0;      tick(H);
    endtask

    task automatic bus_stop();
        sda_host = 1'b0; tick(H);
        scl = 1'b1;      tick(H);
        sda_host = 1'b1; tick(H);
    endtask

    task automatic put_bit(input logic b);
        sda_host = b; tick(H);
        scl = 1'b1;   tick(H);
        scl = 1'b0;   tick(2);
    endtask

    task automatic get_bit(output logic b);
        sda_host = 1'b1; tick(H);
        scl = 1'b1;      tick(H / 2);
        b = sda_line;    tick(H / 2);
        scl = 1'b0;      tick(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            b[i] = x;
        end
        put_bit(~give_ack);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] p, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                            input logic [7:0] d3, input logic [7:0] d4);
        logic ak;
        logic [7:0] dat [5];
        logic [3:0] idx;
        bit m;
        dat[0] = d0; dat[1] = d1; dat[2] = d2; dat[3] = d3; dat[4] = d4;
        m = exp_match(a, strap, en);
        bus_start();
        send_byte({a, 1'b0}, ak);
        chk(ak == m, "R1/R2 write address ack", int'(ak), int'(m));
        send_byte(p, ak);
        chk(ak == m, "R3 pointer byte ack", int'(ak), int'(m));
        idx = p[3:0];
        for (int k = 0; k < n; k++) begin
            send_byte(dat[k], ak);
            chk(ak == m, "R3 data byte ack", int'(ak), int'(m));
            if (m) ref_regs[idx] = dat[k];
            idx = idx + 4'd1;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] p, input int n);
        logic ak;
        logic [7:0] d, exp;
        logic [3:0] idx;
        bit m;
        m = exp_match(a, strap, en);
        bus_start();
        send_byte({a, 1'b0}, ak);
        chk(ak == m, "R1/R2 address ack before read", int'(ak), int'(m));
        send_byte(p, ak);
        chk(ak == m, "R3 read pointer ack", int'(ak), int'(m));
        bus_start();
        send_byte({a, 1'b1}, ak);
        chk(ak == m, "R5 read address ack", int'(ak), int'(m));
        idx = p[3:0];
        for (int k = 0; k < n; k++) begin
            recv_byte(d, k < n - 1);
            exp = m ? ref_regs[idx] : 8'hFF;
            chk(d == exp, "R5/R4 read data", int'(d), int'(exp));
            idx = idx + 4'd1;
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ak;
        logic [7:0] d;
        logic [6:0] own, other;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 16; i++) ref_regs[i] = 8'h00;

        tick(5);
        rst = 1'b0;
        tick(1);
        // R10: reset state
        chk(sda_oe == 1'b0, "R10 sda_oe after reset", int'(sda_oe), 0);
        chk(bus_idle == 1'b0, "R10 bus_idle after reset", int'(bus_idle), 0);
        own = {3'b101, strap};
        do_read(own, 8'h00, 16); // R10 all registers zero

        // R9: idle after long high
        tick(IDLE + 20);
        chk(bus_idle == 1'b1, "R9 bus_idle after timeout", int'(bus_idle), 1);

        // R3/R4: write wraps 14,15,0; upper pointer bits ignored
        do_write(own, 8'hFE, 3, 8'hA1, 8'hB2, 8'hC3, 8'h00, 8'h00);
        do_read(own, 8'h0E, 4); // R4 read wrap

        // R2: foreign address, bus must stay untouched by slave
        other = own ^ 7'h01;
        drive_viol = 0;
        watch_silent = 1'b1;
        do_write(other, 8'h02, 2, 8'h55, 8'h66, 8'h00, 8'h00, 8'h00);
        watch_silent = 1'b0;
        chk(drive_viol == 0, "R2 no SDA drive on mismatch", drive_viol, 0);
        do_read(own, 8'h02, 2);

        // R7: enable low
        en = 1'b0;
        drive_viol = 0;
        watch_silent = 1'b1;
        do_write(own, 8'h04, 2, 8'h77, 8'h88, 8'h00, 8'h00, 8'h00);
        watch_silent = 1'b0;
        chk(drive_viol == 0, "R7 no SDA drive while disabled", drive_viol, 0);
        en = 1'b1;
        tick(4);
        do_read(own, 8'h04, 2);

        // R6: NACK ends the read, slave stays silent
        do_write(own, 8'h09, 2, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h00);
        bus_start();
        send_byte({own, 1'b0}, ak);
        send_byte(8'h09, ak);
        bus_start();
        send_byte({own, 1'b1}, ak);
        chk(ak == 1'b1, "R5 read address ack", int'(ak), 1);
        recv_byte(d, 1'b0);
        chk(d == 8'h00, "R6 single byte read", int'(d), 0);
        for (int i = 7; i >= 0; i--) begin
            logic x;
            get_bit(x);
            d[i] = x;
        end
        chk(d == 8'hFF, "R6 released after NACK", int'(d), 8'hFF);
        bus_stop();

        // R8: START in the middle of a data byte drops the partial byte
        bus_start();
        send_byte({own, 1'b0}, ak);
        send_byte(8'h07, ak);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_start();
        send_byte({own, 1'b0}, ak);
        chk(ak == 1'b1, "R8 address after mid-byte START", int'(ak), 1);
        send_byte(8'h08, ak);
        send_byte(8'h9D, ak);
        chk(ak == 1'b1, "R8 data ack after restart", int'(ak), 1);
        ref_regs[8] = 8'h9D;
        bus_stop();
        do_read(own, 8'h07, 2);

        // R9: SCL held high aborts the transaction
        bus_start();
        chk(bus_idle == 1'b0, "R9 bus_idle low during transfer", int'(bus_idle), 0);
        send_byte({own, 1'b0}, ak);
        sda_host = 1'b1;
        tick(2);
        scl = 1'b1;
        tick(IDLE + 20);
        chk(bus_idle == 1'b1, "R9 timeout with SCL stuck high", int'(bus_idle), 1);
        scl = 1'b0;
        tick(2);
        send_byte(8'h01, ak);
        chk(ak == 1'b0, "R9 no ack after abort", int'(ak), 0);
        send_byte(8'hEE, ak);
        chk(ak == 1'b0, "R9 data ignored after abort", int'(ak), 0);
        bus_stop();
        do_read(own, 8'h00, 2);

        // Random mix: R1 R3 R4 R5 with changing straps
        for (int it = 0; it < 14; it++) begin
            logic [6:0] a;
            logic [7:0] p;
            int n;
            if ($urandom_range(3) == 0) strap = 4'($urandom);
            own = {3'b101, strap};
            a = own;
            if ($urandom_range(3) == 0) begin
                a = 7'($urandom);
                if (a == own) a = a ^ 7'h10;
            end
            p = 8'($urandom);
            n = $urandom_range(5, 1);
            if ($urandom_range(1) == 0)
                do_write(a, p, n, 8'($urandom), 8'($urandom), 8'($urandom),
                         8'($urandom), 8'($urandom));
            else
                do_read(a, p, n);
        end
        do_read(own, 8'h00, 16);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule